// File: doc/BRIEF.md
# Biphase Audio Link Transmitter with Data-Burst Framing

This block drives a one-wire consumer digital audio link. It builds a stream of 32-slot subframes and line-codes it with biphase-mark coding. The block runs from the audio master clock, and every half bit-cell lasts `HALF_DIV` clocks. With the default of 2, a 256fs clock gives one 64-slot frame per sample period. A value of 3 suits a 384fs clock and a value of 4 suits a 512fs clock.

The link runs in one of two modes, and never both at once. In PCM mode, each subframe carries a 24-bit sample from `data_in`. In data mode, the link carries compressed bursts as a stream of 16-bit words, one word per subframe. The two subframes of a frame together form a 32-bit word pair. Each burst opens with four header words: two sync words, a payload descriptor (which holds the bitstream number) and the payload length in bits. The payload words follow, taken from `data_in[15:0]`. The rest of the burst period is filled with zero words.

The host sets the mode, the descriptor, the payload length, the repetition period, the user bit and the first channel-status bits through static configuration inputs. The block asks for each new sample or payload word with a one-cycle `data_take` strobe.

Top module: `spdif_burst_tx`

## Requirements
- R1: While `rst_n` is low, `dout` and `data_take` are 0.
- R2: `dout` changes only on half-cell boundaries, which come every `HALF_DIV` clocks. The first boundary is the first clock edge after reset is released.
- R3: Slots 4 to 31 use biphase-mark coding. The level inverts at the start of every cell, and inverts again mid-cell when the bit is 1.
- R4: Slots 0 to 3 carry a preamble of 8 half-cells, sent first to last. Taken with a previous level of 0, the preamble is B=11101000, M=11100010 or W=11100100, and it is inverted when the previous level is 1. Channel 2 always uses W. Channel 1 uses B in frame 0 of each 192-frame block, and M in every other frame.
- R5: Slot 31 makes slots 4 to 31 even parity.
- R6: A burst starts with four words, each in its own subframe and starting on channel 1: 0xF872, 0x4E1F, the descriptor `cfg_info`, and `cfg_len`×16.
- R7: In data mode, a 16-bit word sits in slots 12 to 27, least significant bit in slot 12. Slots 4 to 11 are 0.
- R8: After `cfg_len` payload words, zero words fill the burst up to a period of max(`cfg_rep`, `cfg_len`+4) words, rounded up to an even number. Length, period and descriptor are sampled only when a burst starts.
- R9: In PCM mode, slots 4 to 27 carry `data_in` with the least significant bit in slot 4. The validity bit in slot 28 is 0 in PCM mode and 1 in data mode.
- R10: Slot 29 carries `cfg_user`. Slot 30 carries bit f of `cfg_cs` in frame f when f < `CS_BITS`, and 0 otherwise. In data mode, frame 1 forces slot 30 to 1.
- R11: `data_take` is high for exactly the one clock in which a subframe is loaded and that subframe consumes `data_in`. That is every subframe in PCM mode, and only payload words in data mode.
- R12: The mode is sampled only when a channel-1 subframe is loaded. Entering data mode starts a new burst at header word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_data_mode | input | 1 | 1 = burst data, 0 = PCM |
| cfg_user | input | 1 | User-data bit placed in every subframe |
| cfg_cs | input | CS_BITS | Channel-status bits for frames 0 to CS_BITS-1 |
| cfg_info | input | 16 | Burst payload descriptor word |
| cfg_len | input | CNT_W | Payload length in 16-bit words |
| cfg_rep | input | CNT_W | Burst repetition period in words |
| data_in | input | 24 | PCM sample, or payload word in bits 15:0 |
| data_take | output | 1 | `data_in` is consumed at this clock edge |
| dout | output | 1 | Biphase-mark coded line output |

## Verification
The hardest situation to reach from the ports is a change of configuration that arrives while a burst is still in flight. Examples are a new length and period written halfway through a burst, or a mode request on a channel-2 subframe. The stimulus writes these at subframe loads chosen so that both cases occur. The bench model then shows that the old burst finishes with its latched length, and that the mode switch waits for the next channel-1 subframe. The run also covers a zero-length burst, a period that must be rounded up to an even number, and more than 192 frames, so that the block-start preamble appears twice.

// File: rtl/spdif_burst_pkg.sv
package spdif_burst_pkg;

  typedef enum logic [1:0] {PRE_B, PRE_M, PRE_W} pre_kind_e;

  localparam logic [15:0] SYNC_WORD_A = 16'hF872;
  localparam logic [15:0] SYNC_WORD_B = 16'h4E1F;

  // Eight half-cell levels, first to last, for a previous line level of 0.
  function automatic logic [7:0] pre_pattern(input pre_kind_e kind);
    case (kind)
      PRE_B:   return 8'b1110_1000;
      PRE_M:   return 8'b1110_0010;
      default: return 8'b1110_0100;
    endcase
  endfunction

  // Slot vector: [3:0] preamble placeholder, [27:4] audio, 28 V, 29 U, 30 C, 31 P.
  function automatic logic [31:0] pack_subframe(input logic [23:0] audio,
                                                input logic v, input logic u,
                                                input logic c);
    logic par;
    par = ^{audio, v, u, c};
    return {par, c, u, v, audio, 4'h0};
  endfunction

endpackage

// File: rtl/spdif_cell_tick.sv
module spdif_cell_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            div_q <= LAST;
    else if (div_q == LAST) div_q <= '0;
    else                   div_q <= div_q + 1'b1;
  end

  assign tick = rst_n && (div_q == LAST);
endmodule

// File: rtl/spdif_word_seq.sv
module spdif_word_seq
  import spdif_burst_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int CS_BITS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               cfg_data_mode,
  input  logic               cfg_user,
  input  logic [CS_BITS-1:0] cfg_cs,
  input  logic [15:0]        cfg_info,
  input  logic [CNT_W-1:0]   cfg_len,
  input  logic [CNT_W-1:0]   cfg_rep,
  input  logic [23:0]        data_in,
  output logic [31:0]        new_sf,
  output pre_kind_e          new_kind,
  output logic               data_take,
  output logic               mode_now
);
  localparam int WW    = CNT_W + 1;
  localparam int CS_IW = (CS_BITS > 1) ? $clog2(CS_BITS) : 1;
  localparam logic [7:0] LAST_FRAME = 8'd191;

  function automatic logic [WW-1:0] burst_period(input logic [CNT_W-1:0] rep,
                                                 input logic [CNT_W-1:0] len);
    logic [WW-1:0] hdr_pay, per;
    hdr_pay = {1'b0, len} + WW'(4);
    per     = (hdr_pay > {1'b0, rep}) ? hdr_pay : {1'b0, rep};
    return per + WW'(per[0]);
  endfunction

  logic               chan_q, mode_q;
  logic [7:0]         frame_q;
  logic [WW-1:0]      word_q, eff_q;
  logic [CNT_W-1:0]   len_q;
  logic [15:0]        info_q;

  logic               restart, fresh, in_pay, cs_bit;
  logic [WW-1:0]      word_use, eff_use, pay_end, word_next;
  logic [CNT_W-1:0]   len_use;
  logic [15:0]        info_use, word16;
  logic [23:0]        audio;

  always_comb begin
    mode_now = chan_q ? mode_q : cfg_data_mode;
    restart  = !chan_q && cfg_data_mode && !mode_q;
    word_use = restart ? '0 : word_q;
    fresh    = (word_use == '0);
    len_use  = fresh ? cfg_len  : len_q;
    info_use = fresh ? cfg_info : info_q;
    eff_use  = fresh ? burst_period(cfg_rep, cfg_len) : eff_q;
    pay_end  = {1'b0, len_use} + WW'(4);
    in_pay   = (word_use >= WW'(4)) && (word_use < pay_end);
    word_next = (word_use == eff_use - WW'(1)) ? '0 : word_use + WW'(1);

    if (word_use == WW'(0))      word16 = SYNC_WORD_A;
    else if (word_use == WW'(1)) word16 = SYNC_WORD_B;
    else if (word_use == WW'(2)) word16 = info_use;
    else if (word_use == WW'(3)) word16 = 16'({len_use, 4'h0});
    else if (in_pay)             word16 = data_in[15:0];
    else                         word16 = 16'h0000;

    cs_bit = (frame_q < 8'(CS_BITS)) ? cfg_cs[frame_q[CS_IW-1:0]] : 1'b0;
    if (mode_now && frame_q == 8'd1) cs_bit = 1'b1;

    audio    = mode_now ? {word16, 8'h00} : data_in;
    new_sf   = pack_subframe(audio, mode_now, cfg_user, cs_bit);
    new_kind = chan_q ? PRE_W : ((frame_q == 8'd0) ? PRE_B : PRE_M);
    data_take = load && (mode_now ? in_pay : 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q  <= 1'b0;
      frame_q <= 8'd0;
      mode_q  <= 1'b0;
      word_q  <= '0;
      eff_q   <= '0;
      len_q   <= '0;
      info_q  <= '0;
    end else if (load) begin
      chan_q <= !chan_q;
      if (chan_q) frame_q <= (frame_q == LAST_FRAME) ? 8'd0 : frame_q + 8'd1;
      mode_q <= mode_now;
      if (mode_now) begin
        word_q <= word_next;
        if (fresh) begin
          len_q  <= len_use;
          info_q <= info_use;
          eff_q  <= eff_use;
        end
      end else begin
        word_q <= '0;
      end
    end
  end
endmodule

// File: rtl/spdif_bmc_ser.sv
module spdif_bmc_ser
  import spdif_burst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [31:0] new_sf,
  input  pre_kind_e   new_kind,
  output logic        load,
  output logic        dout
);
  logic [5:0]  half_q;
  logic [31:0] sf_q;
  pre_kind_e   kind_q;
  logic        ref_q;
  logic [5:0]  hn;
  logic [7:0]  new_pat, cur_pat;

  assign load    = tick && (half_q == 6'd63);
  assign hn      = half_q + 6'd1;
  assign new_pat = pre_pattern(new_kind);
  assign cur_pat = pre_pattern(kind_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 6'd63;
      sf_q   <= '0;
      kind_q <= PRE_B;
      ref_q  <= 1'b0;
      dout   <= 1'b0;
    end else if (tick) begin
      if (half_q == 6'd63) begin
        half_q <= 6'd0;
        sf_q   <= new_sf;
        kind_q <= new_kind;
        ref_q  <= dout;
        dout   <= new_pat[7] ^ dout;
      end else begin
        half_q <= hn;
        if (hn < 6'd8)   dout <= cur_pat[3'(3'd7 - hn[2:0])] ^ ref_q;
        else if (!hn[0]) dout <= !dout;
        else             dout <= dout ^ sf_q[hn[5:1]];
      end
    end
  end
endmodule

// File: rtl/spdif_burst_tx.sv
module spdif_burst_tx
  import spdif_burst_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int CNT_W    = 12,
  parameter int CS_BITS  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_data_mode,
  input  logic               cfg_user,
  input  logic [CS_BITS-1:0] cfg_cs,
  input  logic [15:0]        cfg_info,
  input  logic [CNT_W-1:0]   cfg_len,
  input  logic [CNT_W-1:0]   cfg_rep,
  input  logic [23:0]        data_in,
  output logic               data_take,
  output logic               dout
);
  logic        tick, load, mode_now;
  logic [31:0] new_sf;
  pre_kind_e   new_kind;

  spdif_cell_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  spdif_word_seq #(.CNT_W(CNT_W), .CS_BITS(CS_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(load),
    .cfg_data_mode(cfg_data_mode), .cfg_user(cfg_user), .cfg_cs(cfg_cs),
    .cfg_info(cfg_info), .cfg_len(cfg_len), .cfg_rep(cfg_rep),
    .data_in(data_in), .new_sf(new_sf), .new_kind(new_kind),
    .data_take(data_take), .mode_now(mode_now)
  );

  spdif_bmc_ser u_ser (
    .clk(clk), .rst_n(rst_n), .tick(tick), .new_sf(new_sf),
    .new_kind(new_kind), .load(load), .dout(dout)
  );
endmodule

// File: rtl/spdif_burst_chk.sv
module spdif_burst_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        load,
  input logic        data_take,
  input logic        dout,
  input logic        mode_now,
  input logic [31:0] new_sf
);
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(dout));

  a_r11_take_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    data_take |=> !data_take);

  a_r11_take_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    data_take |-> load);

  a_r7_low_slots_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mode_now) |-> (new_sf[11:4] == 8'h00));

  a_r9_validity_tracks_mode: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (new_sf[28] == mode_now));

  a_r5_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (($countones(new_sf[31:4]) % 2) == 0));
endmodule

bind spdif_burst_tx spdif_burst_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
  .data_take(data_take), .dout(dout), .mode_now(mode_now), .new_sf(new_sf)
);

// File: tb/tb_spdif_burst_tx.sv
module tb_spdif_burst_tx;
  localparam int D       = 2;
  localparam int SF      = 64 * D;
  localparam int NSUB    = 400;
  localparam int CNT_W   = 12;
  localparam int CS_BITS = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_data_mode, cfg_user;
  logic [CS_BITS-1:0] cfg_cs;
  logic [15:0] cfg_info;
  logic [CNT_W-1:0] cfg_len, cfg_rep;
  logic [23:0] data_in;
  logic data_take, dout;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spdif_burst_tx #(.HALF_DIV(D), .CNT_W(CNT_W), .CS_BITS(CS_BITS)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_data_mode(cfg_data_mode), .cfg_user(cfg_user),
    .cfg_cs(cfg_cs), .cfg_info(cfg_info), .cfg_len(cfg_len), .cfg_rep(cfg_rep),
    .data_in(data_in), .data_take(data_take), .dout(dout)
  );

  // Behavioural reference state
  int  m_chan = 0, m_frame = 0, m_word = 0, m_len = 0, m_eff = 0, take_cnt = 0;
  bit  m_mode = 0, m_line = 0, exp_take = 0;
  logic [15:0] m_info = 0;
  bit  lev [64];
  string tag [64];

  function automatic logic [23:0] gen(int n);
    return 24'((n * 24'h3B5A1 + 24'h1234) ^ (n << 7));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic build();
    bit mode;
    bit [31:0] s;
    logic [15:0] w;
    logic [7:0] pat;
    string ctag;
    int ones, cur, per;
    bit req12;
    req12 = (m_chan == 1) && (cfg_data_mode != m_mode);
    if (m_chan == 0) begin
      if (cfg_data_mode && !m_mode) m_word = 0;   // R12 restart
      mode = cfg_data_mode;
    end else mode = m_mode;
    s = 0;
    exp_take = 0;
    if (mode) begin
      if (m_word == 0) begin
        m_len = int'(cfg_len); m_info = cfg_info;
        per = (m_len + 4 > int'(cfg_rep)) ? m_len + 4 : int'(cfg_rep);
        m_eff = per + (per % 2);
      end
      if (m_word == 0) begin w = 16'hF872; ctag = "R6"; end
      else if (m_word == 1) begin w = 16'h4E1F; ctag = "R6"; end
      else if (m_word == 2) begin w = m_info; ctag = "R6"; end
      else if (m_word == 3) begin w = 16'(m_len * 16); ctag = "R6"; end
      else if (m_word < m_len + 4) begin
        w = gen(take_cnt)[15:0]; exp_take = 1; ctag = "R7";
      end else begin w = 0; ctag = "R8"; end
      for (int i = 0; i < 16; i++) s[12 + i] = w[i];
      m_word = (m_word + 1 == m_eff) ? 0 : m_word + 1;
    end else begin
      logic [23:0] smp;
      smp = gen(take_cnt);
      exp_take = 1;
      for (int i = 0; i < 24; i++) s[4 + i] = smp[i];
      ctag = "R9";
      m_word = 0;
    end
    if (req12) ctag = "R12";
    s[28] = mode;
    s[29] = cfg_user;
    s[30] = (m_frame < CS_BITS) ? cfg_cs[m_frame] : 1'b0;
    if (mode && m_frame == 1) s[30] = 1'b1;
    ones = 0;
    for (int i = 4; i < 31; i++) ones += s[i];
    s[31] = ones % 2;
    if (m_chan == 1) pat = 8'hE4; else if (m_frame == 0) pat = 8'hE8; else pat = 8'hE2;
    for (int i = 0; i < 8; i++) begin lev[i] = pat[7 - i] ^ m_line; tag[i] = "R4"; end
    cur = lev[7];
    for (int k = 4; k < 32; k++) begin
      lev[2*k]     = !cur;
      lev[2*k + 1] = !cur ^ s[k];
      cur          = lev[2*k + 1];
      tag[2*k]     = "R3";
      tag[2*k + 1] = (k == 31) ? "R5" : (k == 28) ? "R9" : (k >= 29) ? "R10" :
                     (mode && k < 12) ? "R7" : ctag;
    end
    m_line = lev[63];
    m_mode = mode;
    if (m_chan == 1) m_frame = (m_frame == 191) ? 0 : m_frame + 1;
    m_chan = 1 - m_chan;
  endtask

  // Configuration script, applied at subframe loads
  task automatic scenario(input int s);
    case (s)
      8:   cfg_data_mode = 1;                               // enter data mode on channel 1
      26:  begin cfg_len = 10; cfg_rep = 3; end             // mid-burst change, R8 latching
      74:  begin cfg_len = 3; cfg_rep = 9; cfg_info = 16'h1B07; cfg_user = 0; end // odd period
      91:  cfg_data_mode = 0;                               // requested on channel 2: R12
      120: begin cfg_data_mode = 1; cfg_len = 0; cfg_rep = 4; end // zero-length burst
      default: ;
    endcase
  endtask

  initial begin
    cfg_data_mode = 0; cfg_user = 1; cfg_cs = 32'hC35A_0F96;
    cfg_info = 16'h0A15; cfg_len = 5; cfg_rep = 12; data_in = 0;
    repeat (4) @(negedge clk);
    check(dout == 1'b0, "R1", "dout in reset", dout, 0);
    check(data_take == 1'b0, "R1", "data_take in reset", data_take, 0);
    rst_n = 1'b1;
    for (int e = 0; e < NSUB * SF; e++) begin
      bit t;
      if (e % SF == 0) begin
        scenario(e / SF);
        data_in = gen(take_cnt);
        build();
        t = exp_take;
      end else t = 0;
      #1;
      check(data_take == t, "R11", "data_take", data_take, t);
      @(posedge clk);
      if (t) take_cnt++;
      @(negedge clk);
      check(dout == lev[(e % SF) / D], ((e % D) != 0) ? "R2" : tag[(e % SF) / D],
            "dout", dout, lev[(e % SF) / D]);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (120000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule